// File: doc/BRIEF.md
# UART Baud Rate Generator with Fractional Stage

This block turns a fast core clock into the two timing strobes a 16450-style UART shifter needs: an oversample tick that fires sixteen times per bit, and a bit tick that fires once per bit. The core clock is first reduced by a power-of-two prescaler. A 16-bit integer divisor then divides it further by twice its value. An optional fractional stage can then divide the result by M + N/2048, where N is an 11-bit numerator. This gives fine control over the rate without a faster clock.

The fractional stage keeps an 11-bit phase accumulator and adds N to it once per oversample period. A period in which the sum carries out of the accumulator is one divided unit longer. Over 2048 periods the mean length is therefore exactly M + N/2048 units. The divisor and M are clamped to a minimum of one, so the strobes can never stop. Any change to a configuration input restarts every counter and clears the accumulator, so the new setting takes effect from a clean phase.

Top module: `uart_baud_gen`

## Requirements
- R1: While `rst_n` is low, both tick outputs are 0. After `rst_n` rises, the first `os_tick` is high in the cycle that follows the P-th rising edge sampling `rst_n` high, where P is the period from R2, R4 or R5.
- R2: With `frac_en` = 0, consecutive `os_tick` pulses are exactly P = 2^`presc_sel` × 2 × `divisor` core cycles apart.
- R3: `presc_sel` covers every value from 0 to 7 and scales P by 2^`presc_sel`, including the extremes 0 and 7.
- R4: With `frac_en` = 1, oversample period k (counted from 0 after a restart) lasts B × (M + c_k) core cycles, where B = 2^`presc_sel` × 2 × `divisor`. The accumulator a starts at 0. c_k is the carry out of the 11-bit sum a + `frac_n`, and a becomes that sum modulo 2048 at the end of each period.
- R5: With `frac_en` = 1 and `frac_n` = 0, every period lasts exactly B × M cycles.
- R6: A `divisor` of 0 behaves as 1, and an `frac_m` of 0 behaves as 1. Ticks keep coming in both cases.
- R7: `os_tick` and `bit_tick` are each high for exactly one core cycle per pulse.
- R8: `bit_tick` is high together with every 16th `os_tick` counted from a restart, the first one on the 16th, and at no other time.
- R9: A change on any of `presc_sel`, `divisor`, `frac_en`, `frac_m` or `frac_n` restarts the block. This holds even for a field the current mode ignores. The cycle after the first edge that samples the new value carries no tick, and the next `os_tick` follows P edges after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_sel | input | 3 | Power-of-two prescale exponent |
| divisor | input | 16 | Integer divisor (0 treated as 1) |
| frac_en | input | 1 | 1 enables the fractional stage |
| frac_m | input | 6 | Integer part of the fractional factor (0 treated as 1) |
| frac_n | input | 11 | Numerator of the fractional part, over 2048 |
| os_tick | output | 1 | One-cycle oversample strobe |
| bit_tick | output | 1 | One-cycle strobe once per 16 oversample ticks |

## Verification
The assertions assume that configuration inputs change only between clock edges and stay stable long enough to be sampled. Any change is then seen as a restart, and only tick gaps fully inside one configuration are compared against the integer formula. They also rely on the period being at least two cycles, which the doubled divisor guarantees, so back-to-back ticks never occur. The stimulus changes configuration only at the falling edge, and it always changes at least one field, so each new setting begins with a restart whose timing can be predicted.

// File: rtl/uart_baud_pkg.sv
// Package: default widths shared by the baud generator and its checker.
// Assumes nothing; holds constants only.
package uart_baud_pkg;
    localparam int unsigned CD_W_DEF  = 3;   // prescale exponent width
    localparam int unsigned DIV_W_DEF = 16;  // integer divisor width
    localparam int unsigned M_W_DEF   = 6;   // fractional integer part width
    localparam int unsigned N_W_DEF   = 11;  // fractional numerator width (denominator 2^N_W)
    localparam int unsigned OVS_DEF   = 16;  // oversample ticks per bit
endpackage

// File: rtl/bg_prescaler.sv
// Power-of-two prescaler: emits a strobe once every 2^cd core cycles.
// Assumes clr is asserted whenever cd changes.
module bg_prescaler #(
    parameter int unsigned CD_W = uart_baud_pkg::CD_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [CD_W-1:0] cd,
    output logic            stb
);
    localparam int unsigned PCNT_W = (1 << CD_W) - 1;

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] lim;

    // Terminal count for the selected exponent (wraps correctly for the top value).
    always_comb begin
        lim = (PCNT_W'(1) << cd) - PCNT_W'(1);
        stb = (pcnt == lim);
    end

    // Free-running count, cleared on reset, restart or terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || stb) pcnt <= '0;
        else                      pcnt <= pcnt + PCNT_W'(1);
    end
endmodule

// File: rtl/bg_divider.sv
// Integer divider: one output strobe per 2*dl input strobes (dl of 0 acts as 1).
// Assumes clr is asserted whenever dl changes.
module bg_divider #(
    parameter int unsigned DIV_W = uart_baud_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_stb,
    input  logic [DIV_W-1:0] dl,
    output logic             out_stb
);
    localparam int unsigned DCNT_W = DIV_W + 1;

    logic [DIV_W-1:0]  dl_eff;
    logic [DCNT_W-1:0] lim;
    logic [DCNT_W-1:0] dcnt;

    // Clamp the divisor and derive the doubled terminal count.
    always_comb begin
        dl_eff  = (dl == '0) ? DIV_W'(1) : dl;
        lim     = {dl_eff, 1'b0} - DCNT_W'(1);
        out_stb = in_stb && (dcnt == lim);
    end

    // Count prescaled strobes, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  dcnt <= '0;
        else if (out_stb)   dcnt <= '0;
        else if (in_stb)    dcnt <= dcnt + DCNT_W'(1);
    end
endmodule

// File: rtl/bg_frac.sv
// Fractional stage: divides base strobes by M or M+1 per period, picking M+1 when
// the N_W-bit phase accumulator carries, so the mean factor is M + N/2^N_W.
// When disabled it passes base strobes straight through and holds the accumulator at 0.
// Assumes clr is asserted whenever en, m or n changes.
module bg_frac #(
    parameter int unsigned M_W = uart_baud_pkg::M_W_DEF,
    parameter int unsigned N_W = uart_baud_pkg::N_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           en,
    input  logic           in_stb,
    input  logic [M_W-1:0] m,
    input  logic [N_W-1:0] n,
    output logic           out_stb
);
    localparam int unsigned FCNT_W = M_W + 1;

    logic [N_W-1:0]    acc;
    logic [N_W:0]      sum;
    logic              carry;
    logic [M_W-1:0]    m_eff;
    logic [FCNT_W-1:0] lim;
    logic [FCNT_W-1:0] fcnt;

    // Period length for this phase: clamped M, plus one when the accumulator carries.
    always_comb begin
        sum     = {1'b0, acc} + {1'b0, n};
        carry   = sum[N_W];
        m_eff   = (m == '0) ? M_W'(1) : m;
        lim     = {1'b0, m_eff} - FCNT_W'(1) + FCNT_W'(carry);
        out_stb = en ? (in_stb && (fcnt == lim)) : in_stb;
    end

    // Count base strobes within the period; advance the phase at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en) begin
            fcnt <= '0;
            acc  <= '0;
        end else if (out_stb) begin
            fcnt <= '0;
            acc  <= sum[N_W-1:0];
        end else if (in_stb) begin
            fcnt <= fcnt + FCNT_W'(1);
        end
    end
endmodule

// File: rtl/bg_bitcnt.sv
// Bit counter: flags every OVS-th oversample strobe since the last clear.
// Assumes os_stb is a single-cycle strobe.
module bg_bitcnt #(
    parameter int unsigned OVS = uart_baud_pkg::OVS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic os_stb,
    output logic bit_stb
);
    localparam int unsigned OCNT_W = (OVS > 1) ? $clog2(OVS) : 1;

    logic [OCNT_W-1:0] ocnt;

    // Bit strobe on the last oversample strobe of the group.
    always_comb bit_stb = os_stb && (ocnt == OCNT_W'(OVS - 1));

    // Count oversample strobes modulo OVS.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ocnt <= '0;
        else if (bit_stb)  ocnt <= '0;
        else if (os_stb)   ocnt <= ocnt + OCNT_W'(1);
    end
endmodule

// File: rtl/uart_baud_gen.sv
// UART baud generator top: prescaler, integer divider, optional fractional stage
// and bit counter in a chain, with registered one-cycle tick outputs.
// Assumes configuration inputs are quasi-static; any change restarts the chain.
module uart_baud_gen #(
    parameter int unsigned CD_W  = uart_baud_pkg::CD_W_DEF,
    parameter int unsigned DIV_W = uart_baud_pkg::DIV_W_DEF,
    parameter int unsigned M_W   = uart_baud_pkg::M_W_DEF,
    parameter int unsigned N_W   = uart_baud_pkg::N_W_DEF,
    parameter int unsigned OVS   = uart_baud_pkg::OVS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CD_W-1:0]  presc_sel,
    input  logic [DIV_W-1:0] divisor,
    input  logic             frac_en,
    input  logic [M_W-1:0]   frac_m,
    input  logic [N_W-1:0]   frac_n,
    output logic             os_tick,
    output logic             bit_tick
);
    localparam int unsigned CFG_W = CD_W + DIV_W + 1 + M_W + N_W;

    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;
    logic             restart;
    logic             clr;
    logic             pre_stb;
    logic             base_stb;
    logic             os_stb;
    logic             bit_stb;

    // Concatenate every configuration field and detect a change against the held copy.
    always_comb begin
        cfg_now = {presc_sel, divisor, frac_en, frac_m, frac_n};
        restart = rst_n && (cfg_now != cfg_q);
        clr     = restart;
    end

    // Hold the configuration; track the inputs during reset so release starts clean.
    always_ff @(posedge clk) begin
        cfg_q <= cfg_now;
    end

    bg_prescaler #(.CD_W(CD_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cd(cfg_q[CFG_W-1 -: CD_W]), .stb(pre_stb)
    );

    bg_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_stb(pre_stb),
        .dl(cfg_q[CFG_W-CD_W-1 -: DIV_W]), .out_stb(base_stb)
    );

    bg_frac #(.M_W(M_W), .N_W(N_W)) u_frac (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(cfg_q[M_W+N_W]), .in_stb(base_stb),
        .m(cfg_q[N_W +: M_W]), .n(cfg_q[N_W-1:0]), .out_stb(os_stb)
    );

    bg_bitcnt #(.OVS(OVS)) u_bit (
        .clk(clk), .rst_n(rst_n), .clr(clr), .os_stb(os_stb), .bit_stb(bit_stb)
    );

    // Register the strobes; a restart suppresses them for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end else begin
            os_tick  <= os_stb;
            bit_tick <= bit_stb;
        end
    end
endmodule

// File: rtl/uart_baud_gen_checker.sv
// Checker for uart_baud_gen: pulse width, bit grouping, restart behaviour and
// integer-mode tick spacing. Bound to the top below.
module uart_baud_gen_checker #(
    parameter int unsigned CD_W  = uart_baud_pkg::CD_W_DEF,
    parameter int unsigned DIV_W = uart_baud_pkg::DIV_W_DEF,
    parameter int unsigned OVS   = uart_baud_pkg::OVS_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic             os_tick,
    input logic             bit_tick,
    input logic [CD_W-1:0]  presc_sel,
    input logic [DIV_W-1:0] divisor,
    input logic             frac_en
);
    int unsigned gap;
    int unsigned os_since;
    logic        seen;
    int unsigned exp_p;

    // Expected integer-mode period from the port values.
    always_comb exp_p = ((divisor == '0) ? 32'd1 : 32'(divisor)) * 32'd2 << presc_sel;

    // Cycles since the last tick and whether a tick has been seen since restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            gap  <= 0;
            seen <= 1'b0;
        end else if (os_tick) begin
            gap  <= 1;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1;
        end
    end

    // Oversample ticks since the last bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) os_since <= 0;
        else if (bit_tick)     os_since <= 0;
        else if (os_tick)      os_since <= os_since + 1;
    end

    a_r7_os_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |=> !os_tick);

    a_r7_bit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    a_r8_bit_with_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    a_r8_bit_every_group: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (os_since == OVS - 1));

    a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!os_tick && !bit_tick));

    a_r2_int_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && seen && !frac_en && !restart) |-> (gap == exp_p));
endmodule

bind uart_baud_gen uart_baud_gen_checker #(.CD_W(CD_W), .DIV_W(DIV_W), .OVS(OVS)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .os_tick(os_tick), .bit_tick(bit_tick),
    .presc_sel(presc_sel), .divisor(divisor), .frac_en(frac_en)
);

// File: tb/uart_baud_gen_tb.sv
// Directed bench for uart_baud_gen: one task per scenario, each checking its results.
module uart_baud_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_WAIT   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  presc_sel = 3'd0;
    logic [15:0] divisor = 16'd3;
    logic        frac_en = 1'b0;
    logic [5:0]  frac_m = 6'd1;
    logic [10:0] frac_n = 11'd0;
    logic        os_tick;
    logic        bit_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    uart_baud_gen u_dut (
        .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .divisor(divisor),
        .frac_en(frac_en), .frac_m(frac_m), .frac_n(frac_n),
        .os_tick(os_tick), .bit_tick(bit_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count rising edges until os_tick is seen high at a falling edge.
    task automatic to_tick(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!os_tick && n < MAX_WAIT);
    endtask

    task automatic apply(input int cd, input int dl, input bit fe, input int m, input int n);
        presc_sel = 3'(cd); divisor = 16'(dl); frac_en = fe; frac_m = 6'(m); frac_n = 11'(n);
    endtask

    // Reference period k of the fractional stage.
    function automatic int frac_period(input int b, input int m, input int n, input int k);
        int acc = 0;
        for (int j = 0; j < k; j++) acc = (acc + n) % 2048;
        return b * (((m == 0) ? 1 : m) + (((acc + n) >= 2048) ? 1 : 0));
    endfunction

    task automatic t_reset;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 os_tick in reset", os_tick, 0);
        chk("R1 bit_tick in reset", bit_tick, 0);
        rst_n = 1'b1;
        to_tick(n); chk("R1 first tick after release", n, 6);
        to_tick(n); chk("R2 gap DL=3", n, 6);
    endtask

    task automatic t_integer;
        int n;
        apply(0, 5, 0, 1, 0);
        to_tick(n); chk("R2 first after DL=5", n, 11);
        to_tick(n); chk("R2 gap DL=5", n, 10);
        to_tick(n); chk("R2 gap DL=5 again", n, 10);
    endtask

    task automatic t_prescale;
        int n;
        apply(2, 3, 0, 1, 0);
        to_tick(n); chk("R3 first CD=2", n, 25);
        to_tick(n); chk("R3 gap CD=2", n, 24);
        apply(7, 1, 0, 1, 0);
        to_tick(n); chk("R3 first CD=7", n, 257);
        to_tick(n); chk("R3 gap CD=7", n, 256);
    endtask

    task automatic t_clamp;
        int n;
        apply(0, 0, 0, 1, 0);
        to_tick(n); chk("R6 DL=0 first", n, 3);
        to_tick(n); chk("R6 DL=0 gap", n, 2);
        apply(0, 1, 1, 0, 0);
        to_tick(n); chk("R6 M=0 first", n, 3);
        to_tick(n); chk("R6 M=0 gap", n, 2);
    endtask

    task automatic t_frac_whole;
        int n;
        apply(1, 2, 1, 3, 0);
        to_tick(n); chk("R5 N=0 first", n, 25);
        to_tick(n); chk("R5 N=0 gap", n, 24);
        to_tick(n); chk("R5 N=0 gap again", n, 24);
    endtask

    task automatic t_fractional(input int cd, input int dl, input int m, input int nn);
        int n;
        int b = (2 << cd) * dl;
        apply(cd, dl, 1, m, nn);
        to_tick(n); chk("R4 first fractional period", n, frac_period(b, m, nn, 0) + 1);
        for (int k = 1; k < 7; k++) begin
            to_tick(n); chk($sformatf("R4 period %0d M=%0d N=%0d", k, m, nn), n, frac_period(b, m, nn, k));
        end
    endtask

    task automatic t_pulse;
        int n;
        apply(0, 2, 0, 1, 0);
        to_tick(n);
        @(posedge clk); @(negedge clk);
        chk("R7 os_tick drops after one cycle", os_tick, 0);
        to_tick(n); chk("R7 remaining gap", n, 3);
    endtask

    task automatic t_bits;
        int n;
        int bad = 0;
        int seen_bits = 0;
        apply(0, 1, 0, 1, 0);
        for (int i = 1; i <= 32; i++) begin
            to_tick(n);
            if (bit_tick) seen_bits++;
            if (bit_tick != ((i % 16) == 0)) bad++;
        end
        chk("R8 bit tick placement errors", bad, 0);
        chk("R8 bit tick count in 32 ticks", seen_bits, 2);
        @(posedge clk); @(negedge clk);
        chk("R8 bit_tick low between groups", bit_tick, 0);
    endtask

    task automatic t_restart;
        int n;
        apply(0, 5, 0, 1, 0);
        to_tick(n);
        @(posedge clk); @(negedge clk);
        frac_n = 11'd5;  // ignored field in integer mode, still restarts
        @(posedge clk); @(negedge clk);
        chk("R9 no tick after restart edge", os_tick, 0);
        n = 0;
        to_tick(n); chk("R9 tick realigned after change", n + 1, 11);
    endtask

    initial begin
        t_reset();
        t_integer();
        t_prescale();
        t_clamp();
        t_frac_whole();
        t_fractional(0, 1, 2, 1024);
        t_fractional(1, 1, 1, 2047);
        t_pulse();
        t_bits();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule